// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a 32-bit pipeline and a word-wide synchronous data memory and carries out word and byte loads and stores. In the request cycle it adds a sign-extended 16-bit displacement to a 32-bit base value. It drives the word address and per-byte write enables, and it puts store data on the correct byte lanes. A word access that is not aligned is refused and flagged.

Lanes are big-endian. The byte whose address has low bits 00 is the most significant byte of the memory word, and the byte at low bits 11 is the least significant byte. Read data from the memory arrives one cycle after the request. The block then selects the addressed byte, or the whole word, and presents it with a one-cycle valid pulse.

Top module: `lsu_align_be`

## Requirements
- R1: The effective address is `base_i + sign_extend(ofs_i)` modulo 2^32. `mem_addr_o` equals bits 31:2 of that address in the request cycle.
- R2: Opcodes are load word 35, store word 43, load byte 32 and store byte 40. Any other opcode raises no `mem_req_o` and produces no `rvalid_o`.
- R3: An aligned store word drives `mem_we_o`=1 and `mem_be_o`=4'b1111, and `mem_wdata_o` equals `wdata_i`.
- R4: A store byte asserts exactly one strobe, `mem_be_o` bit (3 - address[1:0]), where bit i enables memory bits 8i+7:8i. It places `wdata_i[7:0]` on that lane. The other three bytes of the word are left unchanged.
- R5: A load byte returns the byte at lane (3 - address[1:0]) of the read word in `rdata_o[7:0]`. Address low bits 00 select bits 31:24.
- R6: A load byte copies bit 7 of the selected byte into `rdata_o[31:8]`.
- R7: A load word returns the full memory word unchanged.
- R8: Load data appears on `rdata_o` with `rvalid_o` high exactly one cycle after an accepted load request. Each accepted load gives exactly one valid cycle.
- R9: A word access whose address has nonzero bits 1:0 raises `misalign_o` in the request cycle. It issues no memory request or write and returns no data. Byte accesses are never misaligned.
- R10: While `rst_ni` is low, and in the first cycle after it rises, `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| op_i | input | 6 | Opcode |
| base_i | input | 32 | Base register value |
| ofs_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Store source register |
| mem_req_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 30 | Memory word address |
| mem_be_o | output | 4 | Byte write strobes, bit i = bits 8i+7:8i |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_rdata_i | input | 32 | Memory read word, one cycle after request |
| rdata_o | output | 32 | Load result |
| rvalid_o | output | 1 | Load result valid |
| misalign_o | output | 1 | Misaligned word access |

## Verification
The hardest case to reach is a byte store that must leave the three neighbouring bytes untouched. Only the strobes show this, and the bytes become visible at the ports only after a later load. The stimulus writes one byte into a word that holds known, distinct initial contents, then reads the whole word back in the next cycle, so a wrong strobe or lane shows up in the returned word. Misaligned stores are followed by a word load of the same word, which proves that nothing was written.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [5:0] {
    OP_LB = 6'd32,
    OP_LW = 6'd35,
    OP_SB = 6'd40,
    OP_SW = 6'd43
  } lsu_op_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int LW = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [OW-1:0]    ofs_i,
  output logic [AW-LW-1:0] word_o,
  output logic [LW-1:0]    lane_o
);
  logic [AW-1:0] ea;
  assign ea     = base_i + {{(AW-OW){ofs_i[OW-1]}}, ofs_i};
  assign word_o = ea[AW-1:LW];
  assign lane_o = ea[LW-1:0];
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int NB = 4,
  parameter int LW = 2
) (
  input  logic            byte_i,
  input  logic [LW-1:0]   lane_i,
  input  logic [8*NB-1:0] wdata_i,
  output logic [NB-1:0]   be_o,
  output logic [8*NB-1:0] wdata_o
);
  // byte offset k lives in strobe NB-1-k (big-endian)
  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam int S = NB - 1 - k;
    assign be_o[S]            = byte_i ? (lane_i == LW'(k)) : 1'b1;
    assign wdata_o[8*S +: 8]  = byte_i ? wdata_i[7:0] : wdata_i[8*S +: 8];
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int NB = 4,
  parameter int LW = 2
) (
  input  logic            byte_i,
  input  logic [LW-1:0]   lane_i,
  input  logic [8*NB-1:0] rdata_i,
  output logic [8*NB-1:0] rdata_o
);
  logic [7:0] sel;
  always_comb begin
    sel = '0;
    for (int k = 0; k < NB; k++)
      if (lane_i == LW'(k)) sel = rdata_i[8*(NB-1-k) +: 8];
  end
  assign rdata_o = byte_i ? {{(8*NB-8){sel[7]}}, sel} : rdata_i;
endmodule

// File: rtl/lsu_align_be.sv
module lsu_align_be
  import lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int NB = 4,
  localparam int DW = 8 * NB,
  localparam int LW = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [5:0]       op_i,
  input  logic [AW-1:0]    base_i,
  input  logic [OW-1:0]    ofs_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-LW-1:0] mem_addr_o,
  output logic [NB-1:0]    mem_be_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             misalign_o
);
  logic [LW-1:0] lane;
  logic is_ld, is_st, is_byte, is_word, ok;

  always_comb begin
    is_ld   = 1'b0;
    is_st   = 1'b0;
    is_byte = 1'b0;
    unique case (op_i)
      OP_LW: is_ld = 1'b1;
      OP_SW: is_st = 1'b1;
      OP_LB: begin is_ld = 1'b1; is_byte = 1'b1; end
      OP_SB: begin is_st = 1'b1; is_byte = 1'b1; end
      default: ;
    endcase
  end

  assign is_word    = (is_ld | is_st) & ~is_byte;

  lsu_agen #(.AW(AW), .OW(OW), .LW(LW)) u_agen (
    .base_i (base_i),
    .ofs_i  (ofs_i),
    .word_o (mem_addr_o),
    .lane_o (lane)
  );

  assign misalign_o = req_i & is_word & (lane != '0);
  assign ok         = req_i & (is_ld | is_st) & ~misalign_o;
  assign mem_req_o  = ok;
  assign mem_we_o   = ok & is_st;

  lsu_store_lane #(.NB(NB), .LW(LW)) u_st (
    .byte_i  (is_byte),
    .lane_i  (lane),
    .wdata_i (wdata_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  logic          rvalid_q, byte_q;
  logic [LW-1:0] lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      byte_q   <= 1'b0;
      lane_q   <= '0;
    end else begin
      rvalid_q <= ok & is_ld;
      if (ok & is_ld) begin
        byte_q <= is_byte;
        lane_q <= lane;
      end
    end
  end

  lsu_load_extract #(.NB(NB), .LW(LW)) u_ld (
    .byte_i  (byte_q),
    .lane_i  (lane_q),
    .rdata_i (mem_rdata_i),
    .rdata_o (rdata_o)
  );

  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/lsu_align_be_chk.sv
module lsu_align_be_chk #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int NB = 4,
  localparam int DW = 8 * NB,
  localparam int LW = $clog2(NB)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [5:0]       op_i,
  input logic [AW-1:0]    base_i,
  input logic [OW-1:0]    ofs_i,
  input logic [DW-1:0]    wdata_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [AW-LW-1:0] mem_addr_o,
  input logic [NB-1:0]    mem_be_o,
  input logic [DW-1:0]    mem_wdata_o,
  input logic [DW-1:0]    mem_rdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             rvalid_o,
  input logic             misalign_o
);
  p_sb_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && op_i == 6'd40) |-> $countones(mem_be_o) == 1);

  p_sw_all_strobes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && op_i == 6'd43) |-> mem_be_o == '1);

  p_load_returns_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> rvalid_o);

  p_rvalid_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(mem_req_o && !mem_we_o));

  p_misalign_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !mem_req_o && !mem_we_o);

  p_lb_sext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(op_i) == 6'd32) |->
      rdata_o[DW-1:8] == {(DW-8){rdata_o[7]}});
endmodule

bind lsu_align_be lsu_align_be_chk #(.AW(AW), .OW(OW), .NB(NB)) u_chk (.*);

// File: tb/lsu_align_be_tb_top.sv
module lsu_align_be_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [5:0]  op = '0;
  logic [31:0] base = '0;
  logic [15:0] ofs = '0;
  logic [31:0] wd = '0;
  logic        mem_req, mem_we, rvalid, misalign;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata, rdata;

  always #4 clk = ~clk;

  lsu_align_be dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .base_i(base),
    .ofs_i(ofs), .wdata_i(wd), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .misalign_o(misalign)
  );

  // memory model and byte-level reference image
  logic [31:0] mem_m [16];
  logic [7:0]  ref_b [64];
  initial begin
    mem_rdata = '0;
    for (int i = 0; i < 64; i++) ref_b[i] = 8'(i * 37 + 5);
    for (int w = 0; w < 16; w++)
      mem_m[w] = {ref_b[4*w], ref_b[4*w+1], ref_b[4*w+2], ref_b[4*w+3]};
  end
  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem_m[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= mem_m[mem_addr[3:0]];
    end

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [5:0] o, logic [31:0] b, logic [15:0] f,
                       logic [31:0] d, string tag);
    logic [31:0] ea, e;
    logic [3:0]  be_e;
    bit ld, st, byt, mis, vld;
    int i;
    @(negedge clk);
    req = 1'b1; op = o; base = b; ofs = f; wd = d;
    ea  = b + {{16{f[15]}}, f};
    ld  = (o == 6'd35) || (o == 6'd32);
    st  = (o == 6'd43) || (o == 6'd40);
    byt = (o == 6'd32) || (o == 6'd40);
    vld = ld || st;
    mis = vld && !byt && ea[1:0] != 2'b00;
    i   = int'(ea[5:0]);
    #1;
    chk(mem_req == (vld && !mis), {tag, " R2 R9 req"}, 32'(mem_req), 32'(vld && !mis));
    chk(misalign == mis, {tag, " R9 flag"}, 32'(misalign), 32'(mis));
    if (vld && !mis)
      chk(mem_addr == ea[31:2], {tag, " R1 addr"}, 32'(mem_addr), 32'(ea[31:2]));
    if (st && !mis) begin
      be_e = byt ? (4'b1000 >> ea[1:0]) : 4'b1111;
      chk(mem_we && mem_be == be_e, {tag, " R3 R4 strobes"}, 32'(mem_be), 32'(be_e));
      if (byt) begin
        chk(mem_wdata[8*(3-ea[1:0]) +: 8] == d[7:0], {tag, " R4 lane data"},
            mem_wdata, d);
        ref_b[i] = d[7:0];
      end else begin
        chk(mem_wdata == d, {tag, " R3 data"}, mem_wdata, d);
        {ref_b[i], ref_b[i+1], ref_b[i+2], ref_b[i+3]} = d;
      end
    end
    if (ld && !mis) begin
      if (byt) e = {{24{ref_b[i][7]}}, ref_b[i]};
      else     e = {ref_b[i], ref_b[i+1], ref_b[i+2], ref_b[i+3]};
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req = 1'b0; op = '0;
    end
  endtask

  // monitor: each valid pulse must match the oldest expected load
  always @(negedge clk)
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 R8 R9 unexpected rvalid", rdata, '0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata == e, {t, " R8 data"}, rdata, e);
      end
    end

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog R8 act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0, "R10 in reset", 32'(rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid == 1'b0, "R10 after reset", 32'(rvalid), 0);

    issue(6'd35, 32'h100, 16'd0, '0, "R7 lw word0");
    issue(6'd35, 32'h120, 16'hFFFC, '0, "R1 negative offset");
    issue(6'd43, 32'h100, 16'd8, 32'hDEADBEEF, "R3 sw");
    issue(6'd35, 32'h104, 16'd4, '0, "R3 R7 lw back");
    issue(6'd40, 32'h114, 16'd2, 32'h123456A5, "R4 sb lane2");
    issue(6'd35, 32'h114, 16'd0, '0, "R4 neighbours kept");
    for (int k = 0; k < 4; k++)
      issue(6'd40, 32'h130, 16'(k), 32'(8'h7E + 8'(k)), "R4 sb each lane");
    issue(6'd35, 32'h130, 16'd0, '0, "R4 R5 lane order");
    for (int k = 0; k < 4; k++)
      issue(6'd32, 32'h103, 16'(k + 1), '0, "R5 R6 lb");
    issue(6'd32, 32'h130, 16'd1, '0, "R6 lb 0x7F positive");
    issue(6'd32, 32'h130, 16'd2, '0, "R6 lb 0x80 negative");
    issue(6'd43, 32'h100, 16'd2, 32'h11111111, "R9 sw misaligned");
    issue(6'd35, 32'h100, 16'd1, '0, "R9 lw misaligned");
    issue(6'd35, 32'h100, 16'd0, '0, "R9 word unchanged");
    issue(6'd36, 32'h100, 16'd0, 32'hFFFFFFFF, "R2 unknown op");
    issue(6'd35, 32'h100, 16'd0, '0, "R2 word unchanged");
    issue(6'd32, 32'h13F, 16'd0, '0, "R9 odd byte ok");
    idle(4);
    chk(exp_q.size() == 0, "R8 all loads returned", 32'(exp_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule